// File: doc/BRIEF.md
# Monophonic Note Gate

This block follows a stream of decoded note events and keeps one voice: the single note now sounding on one chosen channel. Each event arrives as a one-cycle strobe. It carries an on/off flag, a channel number, a key number and a velocity. The block drives a gate line, the held key and the held velocity straight into a monophonic oscillator.

Events for other channels are dropped. A note-on for the chosen channel takes over the voice at once, whether or not a note is already sounding. A note-off ends the voice only when its key matches the held key. So a late release of a note that has already been replaced cannot cut off the newer one. Key and velocity keep their values after the gate falls, so a release stage further on can still use them.

Top module: `mono_note_gate`

## Requirements
- R1: After reset, `gate` is 0, `cur_key` is 0 and `cur_vel` is 0.
- R2: An event with `ev_valid`=1, `ev_note_on`=1 and `ev_chan` equal to `MATCH_CHAN` (default 3) sets `gate`=1, `cur_key`=`ev_key` and `cur_vel`=`ev_vel` in the cycle after the strobe edge.
- R3: Such a note-on, when `gate` is already 1, replaces `cur_key` and `cur_vel` in the next cycle, and `gate` stays 1.
- R4: An event whose `ev_channel` differs from `MATCH_CHAN` leaves `gate`, `cur_key` and `cur_vel` unchanged, whether it is a note-on or a note-off.
- R5: A note-off (`ev_note_on`=0) on the matched channel whose `ev_key` differs from `cur_key` leaves all three outputs unchanged.
- R6: A note-off on the matched channel whose `ev_key` equals `cur_key` clears `gate` in the next cycle. Its velocity is not stored.
- R7: After the gate is cleared, `cur_key` and `cur_vel` keep their last values until the next accepted note-on.
- R8: In a cycle with `ev_valid`=0, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One-cycle event strobe |
| ev_note_on | input | 1 | 1 = note-on, 0 = note-off |
| ev_chan | input | CHAN_W (4) | Event channel number |
| ev_key | input | KEY_W (7) | Event key number |
| ev_vel | input | VEL_W (7) | Event velocity |
| gate | output | 1 | High while a note sounds |
| cur_key | output | KEY_W (7) | Key of the held or last note |
| cur_vel | output | VEL_W (7) | Velocity of the held or last note |

## Verification
The hardest case to reach is a stale release: a note-off on the matched channel that names a key held earlier but since replaced, while the gate is still high. A random key rarely lands on the old key at the right moment. The stimulus therefore draws keys from a small pool of five values and weights channel 3 heavily, so replacements followed by stale and matching releases occur often. A directed sequence first plays two overlapping notes and releases the older one before the newer one, then releases again after the gate is low.

// File: rtl/mono_gate_pkg.sv
package mono_gate_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_START = 2'd1,
      ACT_STOP  = 2'd2
   } voice_act_e;
endpackage

// File: rtl/mng_event_decode.sv
module mng_event_decode
   import mono_gate_pkg::*;
#(
   parameter int CHAN_W     = 4,
   parameter int KEY_W      = 7,
   parameter int MATCH_CHAN = 3
) (
   input  logic              ev_valid,
   input  logic              ev_note_on,
   input  logic [CHAN_W-1:0] ev_chan,
   input  logic [KEY_W-1:0]  ev_key,
   input  logic [KEY_W-1:0]  held_key,
   output voice_act_e        act
);
   localparam logic [CHAN_W-1:0] MATCH_L = CHAN_W'(MATCH_CHAN);

   logic chan_hit;
   logic key_hit;

   assign chan_hit = ev_valid && (ev_chan == MATCH_L);
   assign key_hit  = (ev_key == held_key);

   always_comb begin
      act = ACT_HOLD;
      if (chan_hit) begin
         if (ev_note_on)   act = ACT_START;
         else if (key_hit) act = ACT_STOP;
      end
   end
endmodule

// File: rtl/mng_voice_reg.sv
module mng_voice_reg
   import mono_gate_pkg::*;
#(
   parameter int KEY_W = 7,
   parameter int VEL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  voice_act_e       act,
   input  logic [KEY_W-1:0] ev_key,
   input  logic [VEL_W-1:0] ev_vel,
   output logic             gate,
   output logic [KEY_W-1:0] key_q,
   output logic [VEL_W-1:0] vel_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate  <= 1'b0;
         key_q <= '0;
         vel_q <= '0;
      end else begin
         unique case (act)
            ACT_START: begin
               gate  <= 1'b1;
               key_q <= ev_key;
               vel_q <= ev_vel;
            end
            ACT_STOP: gate <= 1'b0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mono_note_gate.sv
module mono_note_gate
   import mono_gate_pkg::*;
#(
   parameter int CHAN_W     = 4,
   parameter int KEY_W      = 7,
   parameter int VEL_W      = 7,
   parameter int MATCH_CHAN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic              ev_note_on,
   input  logic [CHAN_W-1:0] ev_chan,
   input  logic [KEY_W-1:0]  ev_key,
   input  logic [VEL_W-1:0]  ev_vel,
   output logic              gate,
   output logic [KEY_W-1:0]  cur_key,
   output logic [VEL_W-1:0]  cur_vel
);
   localparam int CHAN_COUNT = 1 << CHAN_W;

   if (CHAN_W < 1 || CHAN_W > 8) begin : g_bad_chan_w
      $error("mono_note_gate: CHAN_W out of range");
   end
   if (KEY_W < 1 || VEL_W < 1) begin : g_bad_width
      $error("mono_note_gate: KEY_W and VEL_W must be positive");
   end
   if (MATCH_CHAN < 0 || MATCH_CHAN >= CHAN_COUNT) begin : g_bad_match
      $error("mono_note_gate: MATCH_CHAN does not fit CHAN_W");
   end

   voice_act_e act;

   mng_event_decode #(
      .CHAN_W(CHAN_W), .KEY_W(KEY_W), .MATCH_CHAN(MATCH_CHAN)
   ) u_dec (
      .ev_valid(ev_valid), .ev_note_on(ev_note_on), .ev_chan(ev_chan),
      .ev_key(ev_key), .held_key(cur_key), .act(act)
   );

   mng_voice_reg #(
      .KEY_W(KEY_W), .VEL_W(VEL_W)
   ) u_voice (
      .clk(clk), .rst_n(rst_n), .act(act), .ev_key(ev_key), .ev_vel(ev_vel),
      .gate(gate), .key_q(cur_key), .vel_q(cur_vel)
   );
endmodule

// File: rtl/mono_note_gate_chk.sv
module mono_note_gate_chk #(
   parameter int CHAN_W     = 4,
   parameter int KEY_W      = 7,
   parameter int VEL_W      = 7,
   parameter int MATCH_CHAN = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic              ev_note_on,
   input logic [CHAN_W-1:0] ev_chan,
   input logic [KEY_W-1:0]  ev_key,
   input logic [VEL_W-1:0]  ev_vel,
   input logic              gate,
   input logic [KEY_W-1:0]  cur_key,
   input logic [VEL_W-1:0]  cur_vel
);
   localparam logic [CHAN_W-1:0] MATCH_L = CHAN_W'(MATCH_CHAN);

   logic hit;
   assign hit = ev_valid && (ev_chan == MATCH_L);

   // R2
   start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit && ev_note_on |=> gate && cur_key == $past(ev_key) && cur_vel == $past(ev_vel));

   // R4
   foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && ev_chan != MATCH_L |=> $stable(gate) && $stable(cur_key) && $stable(cur_vel));

   // R5
   stale_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !ev_note_on && ev_key != cur_key |=> $stable(gate) && $stable(cur_key) && $stable(cur_vel));

   // R6
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !ev_note_on && ev_key == cur_key |=> !gate && $stable(cur_key) && $stable(cur_vel));

   // R8
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> $stable(gate) && $stable(cur_key) && $stable(cur_vel));
endmodule

bind mono_note_gate mono_note_gate_chk #(
   .CHAN_W(CHAN_W), .KEY_W(KEY_W), .VEL_W(VEL_W), .MATCH_CHAN(MATCH_CHAN)
) u_chk (.*);

// File: tb/sim_mono_note_gate.sv
module sim_mono_note_gate;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_valid = 1'b0;
   logic       ev_note_on = 1'b0;
   logic [3:0] ev_chan = '0;
   logic [6:0] ev_key = '0;
   logic [6:0] ev_vel = '0;
   logic       gate;
   logic [6:0] cur_key;
   logic [6:0] cur_vel;

   int total = 0;
   int failed = 0;

   logic       m_gate = 1'b0;
   logic [6:0] m_key = '0;
   logic [6:0] m_vel = '0;

   always #5 clk = ~clk;

   mono_note_gate u0 (.*);

   function automatic string tag_for(input logic on, input logic [3:0] ch,
                                     input logic [6:0] k);
      if (ch != 4'd3)   return "R4";
      if (on)           return m_gate ? "R3" : "R2";
      if (k != m_key)   return "R5";
      return "R6";
   endfunction

   task automatic check(input string req);
      total++;
      if (gate !== m_gate || cur_key !== m_key || cur_vel !== m_vel) begin
         failed++;
         $display("FAIL %s: got gate=%0b key=%0d vel=%0d, want gate=%0b key=%0d vel=%0d",
                  req, gate, cur_key, cur_vel, m_gate, m_key, m_vel);
      end
   endtask

   // drive at a falling edge, check at the next falling edge
   task automatic send(input logic on, input logic [3:0] ch,
                       input logic [6:0] k, input logic [6:0] v);
      string req;
      req = tag_for(on, ch, k);
      ev_valid = 1'b1; ev_note_on = on; ev_chan = ch; ev_key = k; ev_vel = v;
      if (ch == 4'd3) begin
         if (on) begin m_gate = 1'b1; m_key = k; m_vel = v; end
         else if (k == m_key) m_gate = 1'b0;
      end
      @(negedge clk);
      ev_valid = 1'b0;
      ev_key = 7'h55; ev_vel = 7'h2A;
      check(req);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check("R8");
      end
   endtask

   initial begin
      #2000000;
      failed++; total++;
      $display("FAIL watchdog: got timeout, want finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");

      // directed
      send(1'b1, 4'd0, 7'd60, 7'd100);   // R4 foreign on
      idle(1);
      send(1'b1, 4'd3, 7'd62, 7'd99);    // R2
      idle(2);
      send(1'b1, 4'd3, 7'd64, 7'd98);    // R3 replace
      send(1'b1, 4'd0, 7'd64, 7'd97);    // R4
      send(1'b0, 4'd3, 7'd62, 7'd0);     // R5 stale release
      idle(1);
      send(1'b0, 4'd5, 7'd64, 7'd0);     // R4 foreign off with same key
      send(1'b0, 4'd3, 7'd64, 7'd11);    // R6
      idle(2);                            // R7: key/vel held
      total++;
      if (cur_key !== 7'd64 || cur_vel !== 7'd98) begin
         failed++;
         $display("FAIL R7: got key=%0d vel=%0d, want key=64 vel=98", cur_key, cur_vel);
      end
      send(1'b0, 4'd3, 7'd64, 7'd5);     // release again while low
      send(1'b1, 4'd3, 7'd0, 7'd127);    // R2 boundary values
      send(1'b1, 4'd3, 7'd127, 7'd0);    // R3
      send(1'b0, 4'd3, 7'd127, 7'd127);  // R6

      // random
      for (int i = 0; i < 400; i++) begin
         logic [3:0] ch;
         logic [6:0] k;
         ch = ($urandom % 4 != 0) ? 4'd3 : 4'($urandom);
         k = 7'(60 + 2 * ($urandom % 5));
         send(1'($urandom), ch, k, 7'($urandom));
         if ($urandom % 3 == 0) idle(1);
      end

      // reset mid-note
      send(1'b1, 4'd3, 7'd70, 7'd70);
      rst_n = 1'b0;
      m_gate = 1'b0; m_key = '0; m_vel = '0;
      @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      idle(1);

      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule